// File: doc/BRIEF.md
# GPIO Interrupt Detector Bank

This block watches a bank of general-purpose input pins and turns selected activity on them into one interrupt request. Each pin carries a four-bit detection field. The field chooses level or edge sensing and picks which polarity counts: high or rising, low or falling, or both edges. A pin raises nothing unless its arm bit is set. Its contribution to the interrupt line also passes through an enable mask.

Pins enter through a two-flop synchroniser. Edges are found by comparing the synchronised sample with the sample one cycle older. Edge hits are held in sticky latches until software clears them by writing ones. Level hits follow the synchronised pin directly.

Software reaches the block through a word-wide register port with a single-cycle write strobe and a combinational read.

Top module: `gpio_irq_bank`

Register word addresses:

| Address | Access | Content |
|---|---|---|
| 0x0 | read/write | arm bits |
| 0x1 | write-one-set | enable mask |
| 0x2 | write-one-clear | enable mask; reads return the enable mask |
| 0x3 | read | raw status |
| 0x4 | read | masked status |
| 0x5 | write-one-clear | edge latches |
| 0x8 + g | read/write | detection fields of pins 8g to 8g+7 |

## Requirements
- R1: After reset, all enable bits, arm bits, detection fields and edge latches are 0. Every readable address returns 0 and `irq` is low.
- R2: The detection field of pin k is stored in the register at word address 8 + k/8, at bit positions (k mod 8)*4 to (k mod 8)*4+3. It reads back exactly as written, and bit 3 has no effect on detection.
- R3: Writing ones to address 1 sets those enable bits. Writing ones to address 2 clears them. A read of address 2 returns the enable mask, and a read of address 1 returns 0.
- R4: A pin whose arm bit (address 0) is clear never shows raw status and never latches an edge, whatever its pin activity.
- R5: Address 4 reads raw status AND enable mask, and `irq` is high exactly when that masked value is non-zero.
- R6: With field bit 2 clear (level), raw status is (bit0 AND pin) OR (bit1 AND NOT pin). A pin change is seen in raw status two rising clock edges after it is applied.
- R7: With field bit 2 set (edge), bit 0 latches rising edges and bit 1 latches falling edges. The latch sets on the third rising clock edge after the pin change and stays set after the pin returns.
- R8: Writing ones to address 5 clears those edge latches and has no effect on level status. If a new edge event reaches a latch in the same cycle as its clear, the latch ends set.
- R9: A write that changes a pin's 4-bit detection field clears that pin's edge latch. A write that leaves the field unchanged does not.
- R10: Field values with bits 0 and 1 both clear (0b000, 0b100) never produce raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPIN | Asynchronous pin inputs |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request, OR of masked status |

## Verification
The hardest case to reach from the ports is an edge event and a write-one clear landing on the same latch in the same cycle. Reaching it means counting the synchroniser and previous-sample registers exactly. The bench drives a falling pin in both-edges mode on an already-set latch and issues the clear strobe on the third clock edge after the pin change. A second hard case is a detection-field rewrite while a latch is held. The bench covers it by rewriting a field with a changed value and with an identical value. Every pin is swept through all sixteen field codes with a low-high-low pattern, and each result is compared against arithmetic expectations.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int FLD_W  = 4;
    localparam int PINS_PER_WORD = DATA_W / FLD_W;

    localparam logic [ADDR_W-1:0] A_ARM    = 4'h0;
    localparam logic [ADDR_W-1:0] A_EN_SET = 4'h1;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 4'h2;
    localparam logic [ADDR_W-1:0] A_RAW    = 4'h3;
    localparam logic [ADDR_W-1:0] A_MASKED = 4'h4;
    localparam logic [ADDR_W-1:0] A_ACK    = 4'h5;
    localparam logic [ADDR_W-1:0] A_FLD0   = 4'h8;

    // detection field bit meanings
    localparam int FB_POS  = 0;   // high level / rising edge
    localparam int FB_NEG  = 1;   // low level / falling edge
    localparam int FB_EDGE = 2;   // 1 = edge, 0 = level
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] async_in,
    output logic [NPIN-1:0] sync_out
);
    typedef struct packed {
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIN-1:0]       smp,
    input  logic [NPIN*FLD_W-1:0] fld,
    input  logic [NPIN-1:0]       arm,
    input  logic [NPIN-1:0]       ack,
    input  logic [NPIN-1:0]       chg,
    output logic [NPIN-1:0]       raw
);
    typedef struct packed {
        logic [NPIN-1:0] prev;
        logic [NPIN-1:0] latch;
    } det_t;

    det_t            st_d, st_q;
    logic [NPIN-1:0] hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp;
        hit       = '0;
        raw       = '0;
        for (int i = 0; i < NPIN; i++) begin
            logic [FLD_W-1:0] f;
            logic             rise, fall, lvl;
            f    = fld[i*FLD_W +: FLD_W];
            rise = smp[i] & ~st_q.prev[i];
            fall = ~smp[i] & st_q.prev[i];
            lvl  = (f[FB_POS] & smp[i]) | (f[FB_NEG] & ~smp[i]);
            hit[i] = arm[i] & f[FB_EDGE] & ((f[FB_POS] & rise) | (f[FB_NEG] & fall));
            if (chg[i])      st_d.latch[i] = 1'b0;
            else if (hit[i]) st_d.latch[i] = 1'b1;
            else if (ack[i]) st_d.latch[i] = 1'b0;
            raw[i] = arm[i] & (f[FB_EDGE] ? st_q.latch[i] : lvl);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.latch & $past(ack & ~hit)) == '0));
    assert_event_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.latch & $past(hit & ~chg)) == $past(hit & ~chg)));
    assert_field_change_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.latch & $past(chg)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int NGRP = NPIN / PINS_PER_WORD;

    initial begin
        assert (NPIN % PINS_PER_WORD == 0 && NPIN <= DATA_W && NGRP <= 8)
            else $error("NPIN must be a multiple of 8 and at most 32");
    end

    typedef struct packed {
        logic [NPIN-1:0]       en;
        logic [NPIN-1:0]       arm;
        logic [NPIN*FLD_W-1:0] fld;
    } cfg_t;

    cfg_t            st_d, st_q;
    logic [NPIN-1:0] ack, chg, smp, raw, masked;
    logic [NPIN-1:0] wbits;

    assign wbits = reg_wdata[NPIN-1:0];

    gpio_irq_sync #(.NPIN(NPIN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (smp)
    );

    gpio_irq_detect #(.NPIN(NPIN)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp),
        .fld   (st_q.fld),
        .arm   (st_q.arm),
        .ack   (ack),
        .chg   (chg),
        .raw   (raw)
    );

    always_comb begin
        st_d = st_q;
        ack  = '0;
        chg  = '0;
        if (reg_wr) begin
            unique case (reg_addr)
                A_ARM:    st_d.arm = wbits;
                A_EN_SET: st_d.en  = st_q.en | wbits;
                A_EN_CLR: st_d.en  = st_q.en & ~wbits;
                A_ACK:    ack      = wbits;
                default: begin
                    for (int g = 0; g < NGRP; g++) begin
                        if (reg_addr == ADDR_W'(int'(A_FLD0) + g)) begin
                            st_d.fld[g*DATA_W +: DATA_W] = reg_wdata;
                            for (int j = 0; j < PINS_PER_WORD; j++) begin
                                chg[g*PINS_PER_WORD + j] =
                                    reg_wdata[j*FLD_W +: FLD_W] !=
                                    st_q.fld[(g*PINS_PER_WORD + j)*FLD_W +: FLD_W];
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign masked = raw & st_q.en;
    assign irq    = |masked;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_ARM:    reg_rdata[NPIN-1:0] = st_q.arm;
            A_EN_CLR: reg_rdata[NPIN-1:0] = st_q.en;
            A_RAW:    reg_rdata[NPIN-1:0] = raw;
            A_MASKED: reg_rdata[NPIN-1:0] = masked;
            default: begin
                for (int g = 0; g < NGRP; g++) begin
                    if (reg_addr == ADDR_W'(int'(A_FLD0) + g))
                        reg_rdata = st_q.fld[g*DATA_W +: DATA_W];
                end
            end
        endcase
    end

    assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_EN_SET) |=> ((st_q.en & $past(wbits)) == $past(wbits)));
    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_EN_CLR) |=> ((st_q.en & $past(wbits)) == '0));
    assert_unarmed_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~st_q.arm) == '0);
    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & st_q.en) != '0));
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
    localparam int  NPIN = 32;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] fm [4];

    gpio_irq_bank #(.NPIN(NPIN)) dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_fld(int p, logic [3:0] c);
        fm[p/8][(p%8)*4 +: 4] = c;
        wr(4'(8 + p/8), fm[p/8]);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int g = 0; g < 4; g++) fm[g] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at every address
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 addr %0d after reset", a), v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R3: enable set / clear / readback
        wr(4'h1, 32'hF0F0_0000);
        rd(4'h2, v); chk("R3 enable after set", v, 32'hF0F0_0000);
        wr(4'h2, 32'h3000_0000);
        rd(4'h2, v); chk("R3 enable after clear", v, 32'hC0F0_0000);
        rd(4'h1, v); chk("R3 set address reads zero", v, 32'h0);
        wr(4'h2, 32'hFFFF_FFFF);
        rd(4'h2, v); chk("R3 enable all cleared", v, 32'h0);

        // R2, R6, R7, R8, R10, R5: every pin through every field code
        for (int p = 0; p < NPIN; p++) begin
            logic [31:0] m;
            m = 32'h1 << p;
            wr(4'h0, m);
            wr(4'h1, m);
            for (int c = 0; c < 16; c++) begin
                logic       ed, hi, lo, e;
                logic [3:0] cc;
                cc = 4'(c);
                ed = cc[2]; hi = cc[0]; lo = cc[1];
                pin_in = '0;
                set_fld(p, cc);
                rd(4'(8 + p/8), v); chk($sformatf("R2 field pin %0d code %0d", p, c), v, fm[p/8]);
                wait_cyc(4);
                wr(4'h5, m);
                rd(4'h3, v);
                e = ed ? 1'b0 : lo;
                chk($sformatf("R6/R10 pin %0d code %0d low", p, c), v, e ? m : 32'h0);
                pin_in = m;
                wait_cyc(4);
                rd(4'h3, v);
                e = hi;
                chk($sformatf("R6/R7 pin %0d code %0d high", p, c), v, e ? m : 32'h0);
                pin_in = '0;
                wait_cyc(4);
                rd(4'h3, v);
                e = ed ? (hi | lo) : lo;
                chk($sformatf("R7 sticky pin %0d code %0d back low", p, c), v, e ? m : 32'h0);
                rd(4'h4, v);
                chk($sformatf("R5 masked pin %0d code %0d", p, c), v, e ? m : 32'h0);
                chk($sformatf("R5 irq pin %0d code %0d", p, c), {31'b0, irq}, {31'b0, e});
                wr(4'h5, m);
                rd(4'h3, v);
                e = ed ? 1'b0 : lo;
                chk($sformatf("R8 after ack pin %0d code %0d", p, c), v, e ? m : 32'h0);
            end
            set_fld(p, 4'h0);
            wr(4'h0, 32'h0);
            wr(4'h2, m);
        end

        // R6 latency: level high on pin 3
        wr(4'h0, 32'h8); wr(4'h1, 32'h8);
        set_fld(3, 4'b0001);
        wait_cyc(4);
        pin_in = 32'h8;
        rd(4'h3, v); chk("R6 level no edge yet", v, 32'h0);
        wait_cyc(1); rd(4'h3, v); chk("R6 level one edge", v, 32'h0);
        wait_cyc(1); rd(4'h3, v); chk("R6 level two edges", v, 32'h8);
        // R7 latency: rising edge
        pin_in = '0;
        set_fld(3, 4'b0101);
        wait_cyc(4);
        wr(4'h5, 32'h8);
        pin_in = 32'h8;
        wait_cyc(2); rd(4'h3, v); chk("R7 edge two edges", v, 32'h0);
        wait_cyc(1); rd(4'h3, v); chk("R7 edge three edges", v, 32'h8);

        // R9: same field value keeps latch, changed value clears it
        set_fld(3, 4'b0101);
        rd(4'h3, v); chk("R9 unchanged field keeps latch", v, 32'h8);
        set_fld(3, 4'b0110);
        rd(4'h3, v); chk("R9 changed field clears latch", v, 32'h0);

        // R8: event and ack in the same cycle, both-edges mode
        set_fld(3, 4'b0111);
        pin_in = '0;
        wait_cyc(4);
        pin_in = 32'h8;
        wait_cyc(4);
        rd(4'h3, v); chk("R8 latch set before race", v, 32'h8);
        pin_in = '0;
        wait_cyc(2);
        reg_addr = 4'h5; reg_wdata = 32'h8; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        rd(4'h3, v); chk("R8 new event beats ack", v, 32'h8);
        wr(4'h5, 32'h8);
        rd(4'h3, v); chk("R8 plain ack clears", v, 32'h0);

        // R5: raw without enable gives no irq
        pin_in = 32'h8;
        wait_cyc(4);
        wr(4'h2, 32'h8);
        rd(4'h3, v); chk("R5 raw with enable off", v, 32'h8);
        rd(4'h4, v); chk("R5 masked with enable off", v, 32'h0);
        chk("R5 irq with enable off", {31'b0, irq}, 32'h0);

        // R4: unarmed pin ignores activity and keeps nothing
        wr(4'h0, 32'h0);
        wr(4'h1, 32'h8);
        wr(4'h5, 32'h8);
        pin_in = '0; wait_cyc(4);
        pin_in = 32'h8; wait_cyc(4);
        pin_in = '0; wait_cyc(4);
        rd(4'h3, v); chk("R4 unarmed raw", v, 32'h0);
        chk("R4 unarmed irq", {31'b0, irq}, 32'h0);
        wr(4'h0, 32'h8);
        rd(4'h3, v); chk("R4 no latch kept while unarmed", v, 32'h0);
        chk("R4 irq after arming", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule